// File: doc/BRIEF.md
# Stepped Digital Volume Attenuator

This block scales each received audio sample before it enters the receive conversion path. Samples are 13-bit two's-complement values, with the sign in bit 12. Each sample comes with its own 3-bit attenuation code. The code picks one of eight gains, spaced 3 dB apart, from 0 dB down to -21 dB.

The gain is applied by multiplying the sample by a 16-bit unsigned constant in Q1.15 format. Code k uses the constant round(32768 * 10^(-3k/20)). The product is rounded to the nearest integer and narrowed back to 13 bits. No gain exceeds one, so the result never leaves the 13-bit range. The code is never stored: the code that arrives with a sample applies to that sample only.

Both sides of the block are valid/ready streams, and a single register stage sits between them.
- A transfer happens on a rising clock edge where valid and ready are both high.
- The producer must hold the sample and the code steady while valid is high and ready is low.
- The input is ready whenever the output stage is empty, or when its content leaves on the same edge.
- An output held while `out_ready` is low keeps both its value and its valid flag.

Top module: `vol_atten_top`

## Requirements
- R1: Code 0 (binary 000) gives 0 dB: the output sample equals the input sample exactly.
- R2: Code k (0 to 7) multiplies the sample by 10^(-3k/20), a step of 3 dB per code value. The output is within 1 LSB of that real-valued product.
- R3: Code 7 (binary 111) gives -21 dB. No output magnitude exceeds the magnitude of the sample it came from, so there is no overflow and no saturation.
- R4: The code accepted with a sample applies to that sample alone. Back-to-back samples that carry different codes each get their own gain.
- R5: The sign bit (bit 12) is kept: a nonzero output has the same sign as its input. Negative full scale (-4096) is handled.
- R6: A sample accepted on a clock edge appears at the output, with `out_valid` high, right after that same edge. The latency is one clock.
- R7: While `out_valid` is high and `out_ready` is low, the output holds its sample and its valid flag, and `in_ready` is low.
- R8: During and right after reset, `out_valid` is low and `out_sample` is zero.
- R9: A zero input sample gives a zero output for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample and code are present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_sample | input | 13 | Two's-complement audio sample, sign in bit 12 |
| in_code | input | 3 | Attenuation code; 0 = 0 dB, 7 = -21 dB |
| out_valid | output | 1 | Output sample is present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_sample | output | 13 | Attenuated two's-complement sample |

## Verification
The checker module tests several properties on every accepted sample:
- the exact pass-through at code 0;
- magnitude never growing, and sign kept;
- a zero input always giving a zero output;
- the one-clock latency;
- the output holding still under back-pressure.

Some properties can only be shown by bench scenarios, because a single-cycle property cannot express them:
- each of the eight gains lying within 1 LSB of the real 10^(-3k/20) curve;
- the code not carrying over between back-to-back samples;
- the values seen just after reset.

// File: rtl/vol_atten_pkg.sv
package vol_atten_pkg;
  localparam int SAMPLE_W  = 13;
  localparam int CODE_W    = 3;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
  localparam int LEVELS    = 1 << CODE_W;

  typedef logic [COEF_W-1:0] coef_t;

  // Q1.15 constants: round(32768 * 10^(-3k/20))
  function automatic coef_t level_coef(input logic [CODE_W-1:0] k);
    case (k)
      3'd0:    level_coef = 16'd32768;
      3'd1:    level_coef = 16'd23198;
      3'd2:    level_coef = 16'd16423;
      3'd3:    level_coef = 16'd11627;
      3'd4:    level_coef = 16'd8231;
      3'd5:    level_coef = 16'd5827;
      3'd6:    level_coef = 16'd4125;
      default: level_coef = 16'd2920;
    endcase
  endfunction
endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom
  import vol_atten_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output coef_t             coef
);
  always_comb coef = level_coef(code);
endmodule

// File: rtl/vol_mult_round.sv
module vol_mult_round #(
  parameter int SW   = 13,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic signed [SW-1:0] sample,
  input  logic        [CW-1:0] coef,
  output logic signed [SW-1:0] result
);
  localparam int PW = SW + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rounded;

  always_comb begin
    prod    = PW'(sample) * PW'($signed({1'b0, coef}));
    rounded = prod + HALF;
    result  = SW'(rounded >>> FRAC);
  end
endmodule

// File: rtl/vol_pipe_reg.sv
module vol_pipe_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic load;

  always_comb begin
    in_ready = !out_valid || out_ready;
    load     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vol_atten_top.sv
module vol_atten_top
  import vol_atten_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [CODE_W-1:0]   in_code,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample
);
  coef_t               coef;
  logic [SAMPLE_W-1:0] scaled;

  vol_gain_rom u_rom (
    .code (in_code),
    .coef (coef)
  );

  vol_mult_round #(
    .SW   (SAMPLE_W),
    .CW   (COEF_W),
    .FRAC (COEF_FRAC)
  ) u_mult (
    .sample ($signed(in_sample)),
    .coef   (coef),
    .result (scaled)
  );

  vol_pipe_reg #(
    .W (SAMPLE_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (scaled),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_sample)
  );
endmodule

// File: rtl/vol_atten_chk.sv
module vol_atten_chk
  import vol_atten_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic [CODE_W-1:0]   in_code,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample
);
  logic            acc;
  logic [SAMPLE_W:0] in_mag;
  logic [SAMPLE_W:0] out_mag;

  always_comb begin
    acc     = in_valid && in_ready;
    in_mag  = in_sample[SAMPLE_W-1]  ? (SAMPLE_W+1)'(-$signed(in_sample))  : {1'b0, in_sample};
    out_mag = out_sample[SAMPLE_W-1] ? (SAMPLE_W+1)'(-$signed(out_sample)) : {1'b0, out_sample};
  end

  assert_unity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_code == '0) |=> out_sample == $past(in_sample));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_mag <= $past(in_mag));

  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_sample == '0) || (out_sample[SAMPLE_W-1] == $past(in_sample[SAMPLE_W-1])));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sample == '0) |=> out_sample == '0);
endmodule

bind vol_atten_top vol_atten_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sample  (in_sample),
  .in_code    (in_code),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample)
);

// File: tb/tb_vol_atten_top.sv
module tb_vol_atten_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int VS [NV] = '{4095, 4095, -4096, 1000, -1000, 2000, -4096, 4095, 0, 1, -1, 3000, -2048};
  localparam int VC [NV] = '{0,    1,    1,     2,    3,     4,    7,     7,    5, 7, 0,  6,    5};
  localparam int VE [NV] = '{4095, 2899, -2900, 501,  -355,  502,  -365,  365,  0, 0, -1, 378,  -364};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_sample = '0;
  logic [2:0]  in_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_atten_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sval(input logic [12:0] v);
    return int'($signed(v));
  endfunction

  // drive one sample, accept on next edge, sample output after it
  task automatic send(input int s, input int c);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 13'(s);
    in_code   = 3'(c);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_ref(input int s, input int c, input string req);
    real g, d;
    g = 10.0 ** (-3.0 * real'(c) / 20.0);
    d = real'(sval(out_sample)) - real'(s) * g;
    if (d < 0.0) d = -d;
    check(out_valid && d <= 1.0, req, sval(out_sample), $rtoi(real'(s) * g));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
    check(out_sample == '0, "R8 sample", sval(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 after release", int'(out_valid), 0);

    // vector table: R1 R2 R3 R5 R9 spot values
    for (int i = 0; i < NV; i++) begin
      send(VS[i], VC[i]);
      begin
        int diff;
        diff = sval(out_sample) - VE[i];
        check(out_valid && diff <= 1 && diff >= -1, "R2 table", sval(out_sample), VE[i]);
      end
      if (VC[i] == 0) check(sval(out_sample) == VS[i], "R1 exact", sval(out_sample), VS[i]);
    end

    // sweep every code against the real model (R2), with R3/R5/R9 checks
    for (int c = 0; c < 8; c++) begin
      for (int s = -4096; s < 4096; s += 37) begin
        send(s, c);
        check_ref(s, c, "R2 sweep");
        if (c == 0) check(sval(out_sample) == s, "R1 sweep", sval(out_sample), s);
        if (c == 7) check(sval(out_sample) * 10 <= (s < 0 ? -s : s) || sval(out_sample) * -10 <= (s < 0 ? -s : s) + 10,
                          "R3 -21dB", sval(out_sample), s / 11);
      end
    end
    send(0, 7);
    check(out_sample == '0, "R9 zero", sval(out_sample), 0);
    send(-4096, 0);
    check(sval(out_sample) == -4096, "R5 neg full scale", sval(out_sample), -4096);

    // R6 latency and R4 per-sample code, streamed back to back
    @(negedge clk);
    in_valid = 1'b1; in_sample = 13'(2000); in_code = 3'd7;
    @(posedge clk);
    @(negedge clk);
    check(out_valid, "R6 one clock", int'(out_valid), 1);
    check(sval(out_sample) == 178, "R4 first code", sval(out_sample), 178);
    in_code = 3'd0;
    @(posedge clk);
    @(negedge clk);
    check(sval(out_sample) == 2000, "R4 code not held", sval(out_sample), 2000);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R6 drains", int'(out_valid), 0);

    // R7 back-pressure
    out_ready = 1'b0;
    send(1000, 0);
    in_valid = 1'b1; in_sample = 13'(-1000); in_code = 3'd2;
    #1;
    check(!in_ready, "R7 in_ready low", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid && sval(out_sample) == 1000, "R7 hold", sval(out_sample), 1000);
    out_ready = 1'b1;
    #1;
    check(in_ready, "R7 ready on drain", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && sval(out_sample) == -501, "R7 next sample", sval(out_sample), -501);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule